// File: doc/BRIEF.md
# Single-Wire Memory Read Sequencer

This block is the byte-level slave command engine of a single-wire memory device that holds 128 bytes of read-only data. A link layer below it deals with the bit slots on the wire. The link layer passes each received byte in over a valid/ready handshake. When the host opens a read slot group, the link layer raises a one-cycle read request, and one cycle later the block returns the byte to be shifted out. Byte bit 0 is the first bit on the wire in both directions, so every byte crosses the interface least significant bit first.

A transaction begins with the selection byte CCh. The function opcode comes next. C3h asks for a paged read, and F0h asks for a whole-array read. Two address bytes follow, low byte first. The block first returns a check CRC computed over the opcode and both address bytes. It then streams memory bytes. In paged mode, a CRC byte follows the last byte of every 32-byte page, so each page the host sees is 33 bytes long. In whole-array mode, a single CRC follows byte 127. After that, every read returns FFh. The storage sits outside the block and is reached through a combinational read port. A bus-reset input aborts any transaction.

Top module: `sw_mem_reader`

## Requirements
- R1: After `rst_n` or a `bus_rst` pulse, `rd_valid` is 0 and `rx_ready` is 1. The block waits for the selection byte, and any read request returns FFh.
- R2: A byte received before the selection byte CCh is discarded. C3h, 00h, 00h sent without a preceding CCh leaves later reads returning FFh.
- R3: The byte that immediately follows CCh is taken as the function opcode. C3h selects the paged read and F0h selects the whole-array read.
- R4: After the opcode, the block takes the address low byte and then the address high byte. The first read returns the CRC of opcode, low byte and high byte, in that order.
- R5: Every read request is answered exactly one cycle later, with `rd_valid` high and the byte on `rd_data`.
- R6: Data starts at the received address. Each read moves on by one byte. In paged mode, the read after the byte at a page offset of 31 returns the CRC of the data bytes sent from that page. The CRC register is cleared at the start of every page.
- R7: After a page CRC, data resumes at the first byte of the next page. Once the CRC after byte 127 has been sent, every later read returns FFh.
- R8: In whole-array mode (F0h), no CRC is inserted at page boundaries. A single CRC over every data byte sent follows byte 127.
- R9: An opcode other than C3h or F0h makes the block ignore all received bytes and return FFh for every read until the next reset.
- R10: A `bus_rst` pulse in the middle of a data stream aborts it. The next read returns FFh, and a fresh sequence then behaves as from reset.
- R11: If the start address is 128 or higher (high byte non-zero, or bit 7 of the low byte set), the address CRC is still returned, and every later read returns FFh.
- R12: `rx_ready` is low while the block is returning the address CRC, data or page CRCs, so bytes offered in that phase are not consumed.
- R13: The CRC generator uses the polynomial x^8 + x^5 + x^4 + 1 and starts from zero. Each byte enters bit 0 first, which gives a reflected feedback mask of 8Ch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Synchronous abort from a wire reset pulse |
| rx_valid | input | 1 | A received byte is offered |
| rx_data | input | 8 | Received byte, bit 0 first on the wire |
| rx_ready | output | 1 | Byte is consumed when high with rx_valid |
| rd_req | input | 1 | Host requests the next byte |
| rd_valid | output | 1 | Reply byte present, one cycle after rd_req |
| rd_data | output | 8 | Reply byte, bit 0 first on the wire |
| mem_addr | output | 7 | Read address to the storage array |
| mem_rdata | input | 8 | Combinational read data from the storage array |

## Verification
A wrong opcode or address decode shows up on the very first read, because the address CRC would not match the value the host computes. A wrong data pointer or a wrong page-boundary count shows up at the port within one page at most: either a data byte appears where a CRC is due, or the CRC value itself is wrong. A CRC register that fails to clear between pages corrupts the next page CRC. A stuck phase shows up as a read that returns FFh too early or too late. Sweeping every start address in both modes reaches each page boundary from every offset.

// File: rtl/sw_mem_reader.sv
module sw_mem_reader #(
  parameter logic [7:0] SKIP_OP  = 8'hCC,
  parameter logic [7:0] PAGE_OP  = 8'hC3,
  parameter logic [7:0] FIELD_OP = 8'hF0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       rx_ready,
  input  logic       rd_req,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic [6:0] mem_addr,
  input  logic [7:0] mem_rdata
);

  typedef enum logic [3:0] {
    S_ROM, S_FUNC, S_ALO, S_AHI, S_ACRC, S_DATA, S_PCRC, S_DONE, S_DEAD
  } st_t;

  st_t        st;
  logic [7:0] ptr, crc;
  logic       field, oob;

  function automatic logic [7:0] crc_upd(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = {1'b0, r[7:1]} ^ 8'h8C;
      else             r = {1'b0, r[7:1]};
    end
    return r;
  endfunction

  assign rx_ready = st inside {S_ROM, S_FUNC, S_ALO, S_AHI, S_DEAD};
  assign mem_addr = ptr[6:0];

  logic take, page_end;
  assign take     = rx_valid && rx_ready;
  assign page_end = field ? (ptr[6:0] == 7'd127) : (ptr[4:0] == 5'd31);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_ROM; ptr <= '0; crc <= '0; field <= 1'b0; oob <= 1'b0;
      rd_valid <= 1'b0; rd_data <= 8'hFF;
    end else if (bus_rst) begin
      st <= S_ROM; ptr <= '0; crc <= '0; field <= 1'b0; oob <= 1'b0;
      rd_valid <= 1'b0; rd_data <= 8'hFF;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= 8'hFF;
      case (st)
        S_ROM: if (take && rx_data == SKIP_OP) st <= S_FUNC;
        S_FUNC: if (take) begin
          crc <= crc_upd(8'h00, rx_data);
          if (rx_data == PAGE_OP) begin
            field <= 1'b0; st <= S_ALO;
          end else if (rx_data == FIELD_OP) begin
            field <= 1'b1; st <= S_ALO;
          end else st <= S_DEAD;
        end
        S_ALO: if (take) begin
          ptr <= rx_data; crc <= crc_upd(crc, rx_data); st <= S_AHI;
        end
        S_AHI: if (take) begin
          oob <= (rx_data != 8'h00) || ptr[7];
          crc <= crc_upd(crc, rx_data); st <= S_ACRC;
        end
        S_ACRC: if (rd_req) begin
          rd_data <= crc; crc <= '0;
          st <= oob ? S_DONE : S_DATA;
        end
        S_DATA: if (rd_req) begin
          rd_data <= mem_rdata;
          crc <= crc_upd(crc, mem_rdata);
          ptr <= ptr + 8'd1;
          if (page_end) st <= S_PCRC;
        end
        S_PCRC: if (rd_req) begin
          rd_data <= crc; crc <= '0;
          st <= ptr[7] ? S_DONE : S_DATA;
        end
        default: ;
      endcase
    end
  end

  // R5
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
    rd_req |=> rd_valid);

  // R1
  bus_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (st == S_ROM && !rd_valid));

  // R6
  page_crc_chk: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
    (st == S_DATA && rd_req && !field && ptr[4:0] == 5'd31) |=> st == S_PCRC);

  // R7
  done_ff_chk: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
    (st == S_DONE && rd_req) |=> rd_data == 8'hFF);

  // R9
  dead_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || bus_rst)
    st == S_DEAD |=> st == S_DEAD);

endmodule

// File: tb/tb_sw_mem_reader.sv
`timescale 1ns/1ps
module tb_sw_mem_reader;
  logic clk = 1'b0, rst_n = 1'b0, bus_rst = 1'b0;
  logic rx_valid = 1'b0, rd_req = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_ready, rd_valid;
  logic [7:0] rd_data, mem_rdata;
  logic [6:0] mem_addr;
  int vectors = 0, miscompares = 0, cycles = 0;
  bit  finished = 0;

  always #4 clk = ~clk;

  sw_mem_reader dut (.clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata));

  function automatic logic [7:0] mval(input int a);
    return 8'(a * 37 + 11);
  endfunction
  assign mem_rdata = mval(int'(mem_addr));

  // R13: reflected x^8+x^5+x^4+1, bit 0 first
  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb = r[0] ^ d[i];
      r = r >> 1;
      if (fb) r = r ^ 8'h8C;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] exp);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    chk("R5 valid", {7'd0, rd_valid}, 8'd1);
    chk(req, rd_data, exp);
  endtask

  task automatic pulse_bus_rst();
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
  endtask

  task automatic run_seq(input bit fld, input logic [15:0] a);
    logic [7:0] op = fld ? 8'hF0 : 8'hC3;
    logic [7:0] c;
    pulse_bus_rst();
    send(8'hCC); send(op); send(a[7:0]); send(a[15:8]);
    c = crc8(crc8(crc8(8'h00, op), a[7:0]), a[15:8]);
    rd_chk("R4 addr crc", c);
    if (a >= 16'd128) begin
      rd_chk("R11", 8'hFF); rd_chk("R11", 8'hFF);
      return;
    end
    c = 8'h00;
    for (int p = int'(a); p < 128; p++) begin
      rd_chk(fld ? "R8 data" : "R6 data", mval(p));
      c = crc8(c, mval(p));
      if (p == 0 && !fld) begin
        chk("R12", {7'd0, rx_ready}, 8'd0);
      end
      if ((!fld && (p % 32) == 31) || p == 127) begin
        rd_chk(fld ? "R8 crc" : "R6 page crc", c);
        c = 8'h00;
      end
    end
    rd_chk("R7 tail", 8'hFF);
    rd_chk("R7 tail", 8'hFF);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid", {7'd0, rd_valid}, 8'd0);
    chk("R1 ready", {7'd0, rx_ready}, 8'd1);
    rd_chk("R1 idle read", 8'hFF);

    send(8'hC3); send(8'h00); send(8'h00);
    rd_chk("R2", 8'hFF);

    pulse_bus_rst();
    send(8'hCC); send(8'h55); send(8'hCC); send(8'hC3); send(8'h00); send(8'h00);
    rd_chk("R9", 8'hFF);
    rd_chk("R9", 8'hFF);

    pulse_bus_rst();
    send(8'hCC); send(8'hC3); send(8'h00); send(8'h00);
    rd_chk("R3 crc", crc8(crc8(crc8(8'h00, 8'hC3), 8'h00), 8'h00));
    for (int i = 0; i < 5; i++) rd_chk("R3 data", mval(i));
    pulse_bus_rst();
    chk("R10 ready", {7'd0, rx_ready}, 8'd1);
    rd_chk("R10", 8'hFF);
    run_seq(1'b0, 16'd40);

    run_seq(1'b0, 16'h0080);
    run_seq(1'b1, 16'h0100);
    run_seq(1'b0, 16'hFFFF);

    for (int s = 0; s < 128; s++) run_seq(1'b0, 16'(s));
    for (int s = 0; s < 128; s += 3) run_seq(1'b1, 16'(s));

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule